// File: doc/BRIEF.md
# Gated Gray-Code Live-Time Counter

This block measures how long an instrument front end has been able to accept events. A live-gate input is high while the front end is waiting for an event. During that time, each cycle of the fast clock advances a prescaler. When the gate is low, the prescaler freezes at its partial value.

Each time the prescaler wraps, a Gray-coded step counter advances by one code. With the default 15-bit prescaler on a 32 MHz clock, one step is 32768 gated cycles, which is 1.024 ms of accumulated live time. The output comes straight from a register and changes by at most one bit per edge. A processor can therefore sample it at any moment, with no relation to this clock, without seeing a torn value. A clear strobe, issued at the start of each frame, zeroes the prescaler and the step counter together.

Top module: `livetime_gray_counter`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `gray_count` reads zero on the following edge, even with `live_gate` high.
- R2: The prescaler advances only on edges where `live_gate` is high. On edges with `live_gate` low it keeps its partial count, so gated cycles add up across gaps in the gate.
- R3: `gray_count` advances once for every 2^PRESCALE_W gated cycles. With the defaults this is 32768 cycles, or 1.024 ms at 32 MHz.
- R4: After n steps since the last reset or clear, `gray_count` equals (n mod 2^COUNT_W) XOR ((n mod 2^COUNT_W) >> 1). This is the reflected binary Gray code of the step count.
- R5: Any two consecutive register values of `gray_count` that are not separated by a clear or reset differ in at most one bit.
- R6: After the last code (only the MSB set), the next step returns `gray_count` to all zeros. That transition also changes a single bit.
- R7: A `clear` pulse zeroes both the prescaler and `gray_count` at the next edge, and takes priority over `live_gate`. A step after a clear therefore needs a full 2^PRESCALE_W new gated cycles.
- R8: `gray_count` changes on exactly the edge that closes the gated cycle in which the prescaler held its all-ones value, and holds steady on all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock (32 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| live_gate | input | 1 | High while live time accrues |
| clear | input | 1 | Frame-start strobe that zeroes all counting state |
| gray_count | output | COUNT_W | Registered Gray-coded live-time step count |

## Verification
Every result appears at the first clock edge after the inputs that cause it. A clear or reset shows zero one edge later. A step appears on the same edge that completes its 2^PRESCALE_W-th gated cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It updates its arithmetic model of the gated-cycle total at that rising edge, then compares the output at the next falling edge. Because of this, any step that arrives one cycle early or late is reported in the very cycle it happens.

// File: rtl/livetime_pkg.sv
package livetime_pkg;
  localparam int LT_PRESCALE_W_DEF = 15;
  localparam int LT_COUNT_W_DEF    = 16;
endpackage

// File: rtl/livetime_prescaler.sv
module livetime_prescaler #(
  parameter int PRESCALE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic live_gate,
  input  logic clear,
  output logic wrap_tick
);
  localparam logic [PRESCALE_W-1:0] PRE_MAX = '1;

  logic [PRESCALE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (live_gate) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign wrap_tick = live_gate && !clear && (pre_q == PRE_MAX);

  AST_PRE_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!live_gate && !clear) |=> $stable(pre_q)); // R2
  AST_PRE_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0)); // R7
endmodule

// File: rtl/livetime_gray_stepper.sv
module livetime_gray_stepper #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  output logic [COUNT_W-1:0] gray_q
);
  logic [COUNT_W-1:0] bin_q;
  logic [COUNT_W-1:0] bin_next;

  assign bin_next = bin_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (step) begin
      bin_q  <= bin_next;
      gray_q <= bin_next ^ (bin_next >> 1);
    end
  end

  AST_ONE_BIT_MOVE: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ($countones(gray_q ^ $past(gray_q)) <= 1)); // R5
  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(gray_q)); // R8
  AST_MOVE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (gray_q != $past(gray_q))); // R3
  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (gray_q == '0)); // R7
endmodule

// File: rtl/livetime_gray_counter.sv
module livetime_gray_counter
  import livetime_pkg::*;
#(
  parameter int PRESCALE_W = LT_PRESCALE_W_DEF,
  parameter int COUNT_W    = LT_COUNT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               live_gate,
  input  logic               clear,
  output logic [COUNT_W-1:0] gray_count
);
  logic wrap_tick;

  livetime_prescaler #(.PRESCALE_W(PRESCALE_W)) u_prescaler (
    .clk       (clk),
    .rst       (rst),
    .live_gate (live_gate),
    .clear     (clear),
    .wrap_tick (wrap_tick)
  );

  livetime_gray_stepper #(.COUNT_W(COUNT_W)) u_stepper (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .step   (wrap_tick),
    .gray_q (gray_count)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (gray_count == '0)); // R1
endmodule

// File: tb/livetime_gray_counter_bench.sv
module livetime_gray_counter_bench;
  localparam int PW = 2;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic live_gate = 1'b0;
  logic clear = 1'b0;
  logic [CW-1:0] gray_count;

  int errors = 0;
  int checks = 0;
  int gated_total = 0;
  logic [CW-1:0] prev_gray = '0;
  logic prev_valid = 1'b0;

  always #5 clk = ~clk;

  livetime_gray_counter #(.PRESCALE_W(PW), .COUNT_W(CW)) u_livetime_gray_counter (
    .clk(clk), .rst(rst), .live_gate(live_gate), .clear(clear), .gray_count(gray_count)
  );

  function automatic logic [CW-1:0] expect_gray(int g);
    int s;
    s = (g >> PW) % (1 << CW);
    return CW'(s ^ (s >> 1));
  endfunction

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(logic g, logic c, string tag);
    live_gate = g;
    clear = c;
    @(posedge clk);
    if (rst || c) gated_total = 0;
    else if (g) gated_total++;
    @(negedge clk);
    check(tag, gray_count, expect_gray(gated_total));
    if (prev_valid && !c) begin
      checks++;
      if ($countones(gray_count ^ prev_gray) > 1) begin
        errors++;
        $display("FAIL R5: actual=%b expected one-bit move from %b", gray_count, prev_gray);
      end
    end
    prev_gray = gray_count;
    prev_valid = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    // R1: reset holds zero even while gated
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, "R1");
    rst = 1'b0;
    prev_valid = 1'b0;
    // R3 R4 R6 R8: continuous gate across two full wraps of the step counter
    for (int i = 0; i < 2 * (1 << (PW + CW)); i++) tick(1'b1, 1'b0, "R3/R4/R6/R8");
    // R6: explicit wrap point, last code then zero
    tick(1'b0, 1'b1, "R7");
    for (int i = 0; i < (1 << (PW + CW)) - 1; i++) tick(1'b1, 1'b0, "R6");
    check("R6", gray_count, CW'(1) << (CW - 1));
    tick(1'b1, 1'b0, "R6");
    check("R6", gray_count, '0);
    // R2: sparse gating, prescaler holds partial count across gaps
    for (int i = 0; i < 300; i++) tick((i % 3) == 0, 1'b0, "R2");
    for (int i = 0; i < 300; i++) tick((i % 7) != 2, 1'b0, "R2");
    // R2: long idle stretch with partial prescaler count
    tick(1'b1, 1'b0, "R2");
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b0, "R2");
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, "R2");
    // R7: clear mid-prescaler, with gate high, then full new period needed
    for (int k = 1; k < (1 << PW); k++) begin
      tick(1'b1, 1'b1, "R7");
      for (int i = 0; i < k; i++) tick(1'b1, 1'b0, "R7");
      tick(1'b1, 1'b1, "R7");
      for (int i = 0; i < (1 << PW); i++) tick(1'b1, 1'b0, "R7");
    end
    // R7: clear after several steps
    for (int i = 0; i < 23; i++) tick(1'b1, 1'b0, "R4");
    tick(1'b0, 1'b1, "R7");
    check("R7", gray_count, '0);
    for (int i = 0; i < 50; i++) tick(1'b1, 1'b0, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule